// File: doc/BRIEF.md
# Peripheral clock enable bank

This block keeps one clock-enable bit per peripheral for up to 64 peripherals. The bits are split into banks of 32. Each bank has three registers:
- a set register, where every 1 written turns a bit on,
- a clear register, where every 1 written turns a bit off,
- a status register, which reads back the current bits.

Because of this split, software never has to read, modify and write back a register to change one peripheral's clock. A plain register bus reaches the registers: an address, a write strobe, write data and combinational read data.

Each enable bit drives one output, which a gating cell outside this block uses. The two lowest peripheral numbers belong to system clocks. Their outputs are tied on, they read back as on, and no write can gate them.

Top module: `pclk_gate_bank`

## Requirements
- R1: A write to the set register (byte offset 0x00 for IDs 0–31, 0x10 for IDs 32–63) turns on every enable whose write-data bit is 1. The new value shows on `clk_en` from the cycle after the write edge.
- R2: A write to the clear register (offset 0x04 for bank 0, 0x14 for bank 1) turns off every gateable enable whose write-data bit is 1. The new value shows on `clk_en` from the cycle after the write edge.
- R3: Enable bits whose write-data bit is 0 keep their value through a set or clear write.
- R4: While `bus_addr` holds a status offset (0x08 for bank 0, 0x18 for bank 1), `bus_rdata` shows that bank's current enables in the same cycle. Peripheral ID n maps to `clk_en[n]` and to status bit n mod 32 of bank n/32.
- R5: IDs 0 and 1 are always on, in `clk_en` and in bank 0 status, and no set or clear write changes them.
- R6: After reset, every gateable enable (IDs 2–63) is 0.
- R7: Reading a set or clear offset, or any address that decodes to no register, returns 0.
- R8: A write to one bank's registers leaves the other bank's enables unchanged.
- R9: With `bus_we` low, the enables do not change, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe; the write takes effect at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| clk_en | output | 64 | Registered clock enable for each peripheral ID |

## Verification
The bench applies three kinds of stimulus:
- Walking single-bit set and clear writes across both banks. These show that each ID lands on its own bit of its own bank, and that the system IDs resist both kinds of write.
- Pseudo-random multi-bit set and clear masks. These separate true set/clear behaviour from a plain overwrite, and show whether unwritten bits are left alone.
- Reads of every offset in the window, including idle cycles with data on the bus. These show whether the decode is clean, whether the status path is correct and whether `bus_we` gates writes.

// File: rtl/pclk_gate_bank.sv
module pclk_gate_bank #(
  parameter int BANK_W  = 32,
  parameter int N_BANKS = 2,
  parameter int N_FIXED = 2,
  parameter int ADDR_W  = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_we,
  input  logic [BANK_W-1:0]           bus_wdata,
  output logic [BANK_W-1:0]           bus_rdata,
  output logic [BANK_W*N_BANKS-1:0]   clk_en
);
  localparam int N_IDS = BANK_W * N_BANKS;
  localparam logic [N_IDS-1:0] FIXED = {{(N_IDS-N_FIXED){1'b0}}, {N_FIXED{1'b1}}};

  logic [N_IDS-1:0] en_q;

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    logic set_hit, clr_hit;
    logic [BANK_W-1:0] keep, nxt;
    assign set_hit = bus_we && bus_addr == ADDR_W'(b*16);
    assign clr_hit = bus_we && bus_addr == ADDR_W'(b*16 + 4);
    assign keep    = ~FIXED[b*BANK_W +: BANK_W];
    assign nxt     = set_hit ? (en_q[b*BANK_W +: BANK_W] |  bus_wdata) :
                     clr_hit ? (en_q[b*BANK_W +: BANK_W] & ~bus_wdata) :
                               en_q[b*BANK_W +: BANK_W];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q[b*BANK_W +: BANK_W] <= '0;
      else        en_q[b*BANK_W +: BANK_W] <= nxt & keep;
    end
  end

  assign clk_en = en_q | FIXED;

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < N_BANKS; b++)
      if (bus_addr == ADDR_W'(b*16 + 8)) bus_rdata = clk_en[b*BANK_W +: BANK_W];
  end
endmodule

// File: rtl/pclk_gate_bank_chk.sv
module pclk_gate_bank_chk #(
  parameter int BANK_W  = 32,
  parameter int N_BANKS = 2,
  parameter int N_FIXED = 2,
  parameter int ADDR_W  = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic                      bus_we,
  input logic [BANK_W-1:0]         bus_wdata,
  input logic [BANK_W-1:0]         bus_rdata,
  input logic [BANK_W*N_BANKS-1:0] clk_en
);
  localparam logic [BANK_W-1:0] FX = {{(BANK_W-N_FIXED){1'b0}}, {N_FIXED{1'b1}}};
  logic [BANK_W-1:0] b0, b1;
  assign b0 = clk_en[0 +: BANK_W];
  assign b1 = clk_en[BANK_W +: BANK_W];

  AST_SET_B0: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == ADDR_W'(0) |=> (b0 & $past(bus_wdata)) == $past(bus_wdata)); // R1
  AST_SET_B1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == ADDR_W'(16) |=> (b1 & $past(bus_wdata)) == $past(bus_wdata)); // R1
  AST_CLR_B0: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == ADDR_W'(4) |=> (b0 & $past(bus_wdata) & ~FX) == '0); // R2
  AST_KEEP_UNWRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == ADDR_W'(0) |=> (b0 & ~$past(bus_wdata)) == ($past(b0) & ~$past(bus_wdata))); // R3
  AST_STATUS_B0: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == ADDR_W'(8) |-> bus_rdata == b0); // R4
  AST_SYS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (b0 & FX) == FX); // R5
  AST_SET_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == ADDR_W'(0) |-> bus_rdata == '0); // R7
  AST_OTHER_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr[ADDR_W-1:4] == '0 |=> $stable(b1)); // R8
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(clk_en)); // R9
endmodule

bind pclk_gate_bank pclk_gate_bank_chk #(
  .BANK_W(BANK_W), .N_BANKS(N_BANKS), .N_FIXED(N_FIXED), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/pclk_gate_bank_test.sv
module pclk_gate_bank_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] clk_en;

  int compared = 0, mismatched = 0;
  logic [63:0] exp_en;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  pclk_gate_bank uut (.*);

  always #2 clk = ~clk;

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1; bus_wdata = d;
    if (a == 8'h00) exp_en[31:0]  = exp_en[31:0]  |  d;
    if (a == 8'h04) exp_en[31:0]  = exp_en[31:0]  & ~d;
    if (a == 8'h10) exp_en[63:32] = exp_en[63:32] |  d;
    if (a == 8'h14) exp_en[63:32] = exp_en[63:32] & ~d;
    exp_en[1:0] = 2'b11;
    @(negedge clk);
    bus_we = 0; bus_wdata = '0;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
    bus_addr = a; #1;
    chk(req, {32'h0, bus_rdata}, {32'h0, exp});
  endtask

  task automatic full(string req);
    chk(req, clk_en, exp_en);
    rd_chk(req, 8'h08, exp_en[31:0]);
    rd_chk(req, 8'h18, exp_en[63:32]);
  endtask

  function automatic logic [31:0] step(logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  initial begin
    exp_en = 64'h3;
    #9 rst_n = 1;
    @(negedge clk);
    full("R6 reset state");
    chk("R5 system ids on", {62'h0, clk_en[1:0]}, 64'h3);

    // R1 R4: walking single set bit per ID
    for (int id = 0; id < 64; id++) begin
      wr(id < 32 ? 8'h00 : 8'h10, 32'h1 << (id % 32));
      full("R1 walking set");
    end
    // R2 R5: walking clear, system IDs resist
    for (int id = 0; id < 64; id++) begin
      wr(id < 32 ? 8'h04 : 8'h14, 32'h1 << (id % 32));
      full("R2 walking clear");
    end
    chk("R5 after clears", clk_en, 64'h3);
    wr(8'h04, 32'hFFFF_FFFF);
    chk("R5 clear all bank0", clk_en, 64'h3);

    // R3 R8: random masks
    for (int i = 0; i < 200; i++) begin
      logic [7:0] a;
      lfsr = step(lfsr);
      a = {3'b000, lfsr[3], 2'b00, lfsr[4], 1'b0} << 0;
      a = (lfsr[3] ? 8'h10 : 8'h00) | (lfsr[4] ? 8'h04 : 8'h00);
      lfsr = step(lfsr);
      wr(a, lfsr & step(lfsr));
      full("R3 R8 random masks");
    end

    // R7: non-status reads return zero
    foreach (exp_en[k]) if (k < 1) begin end
    for (int a = 0; a < 64; a++) begin
      logic [31:0] e;
      e = (a == 8) ? exp_en[31:0] : (a == 24) ? exp_en[63:32] : 32'h0;
      rd_chk(a == 8 || a == 24 ? "R4 status read" : "R7 undecoded read", a[7:0], e);
    end

    // R9: idle bus with data on it
    for (int a = 0; a < 32; a += 4) begin
      @(negedge clk);
      bus_addr = a[7:0]; bus_we = 0; bus_wdata = 32'hFFFF_FFFF;
      @(negedge clk);
      chk("R9 no write without strobe", clk_en, exp_en);
    end
    bus_wdata = '0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 4);
    compared++; mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule